// File: doc/BRIEF.md
# Packed Logic, Shift and Compare Unit

This block is a single-cycle SIMD datapath for 64-bit packed operands. One request per cycle carries two operands, a shift count, an operation code and a lane-size select. The result is captured in an output register on the next clock edge. Three families of operation are supported:

- **Bitwise** operations across the whole 64-bit word.
- **Shifts** of the first operand, with every lane moved by one shared count.
- **Lane-wise comparisons**, each producing a mask per lane.

A shift count of at least the lane width does not wrap. A logical shift then clears every lane, and an arithmetic shift fills every lane with its sign bit. The count input is a full 64-bit unsigned quantity.

Operation codes are `0` AND, `1` OR, `2` XOR, `3` ANDN, `4` SLL, `5` SRL, `6` SRA, `7` CEQ and `8` CGT. Codes 9 to 15 are not defined. The lane select is `0` for 8-bit lanes, `1` for 16-bit, `2` for 32-bit and `3` for 64-bit. Lane `i` of width `w` occupies bits `[i*w +: w]`.

Top module: `plsc_unit`

## Requirements
- R1: While `rst_n` is low, `result` is zero and `out_vld` is low.
- R2: `out_vld` is high in the cycle after a cycle with `in_vld` high. It is low in the cycle after a cycle with `in_vld` low. The result of a request appears on `result` in the same cycle that `out_vld` rises.
- R3: In a cycle with `in_vld` low, `result` keeps its value, whatever the other inputs carry.
- R4: Op codes 0, 1 and 2 return `opa & opb`, `opa | opb` and `opa ^ opb` over all 64 bits, for any lane select.
- R5: Op code 3 returns `(~opa) & opb` over all 64 bits.
- R6: Op code 4 shifts each lane of `opa` left and op code 5 shifts each lane right, filling with zeros. This holds for lane selects 1, 2 and 3 when `shcnt` is below the lane width.
- R7: Op code 6 shifts each lane of `opa` right, copying the lane's sign bit in. This holds for lane selects 1 and 2 when `shcnt` is below the lane width.
- R8: For op codes 4 and 5, a `shcnt` (read as 64-bit unsigned) of at least the lane width makes every lane zero. This includes counts with only high bits set.
- R9: For op code 6, a `shcnt` of at least the lane width sets every lane to all copies of its own sign bit.
- R10: Op code 7 sets each lane to all ones when the `opa` and `opb` lanes are equal and to all zeros otherwise. This holds for lane selects 0, 1 and 2.
- R11: Op code 8 sets each lane to all ones when the `opa` lane is greater than the `opb` lane as signed two's-complement values, and to all zeros otherwise. This holds for lane selects 0, 1 and 2.
- R12: The result is zero for any of these requests: op codes 9 to 15, shifts with lane select 0, op code 6 with lane select 3, and comparisons with lane select 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request valid |
| op | input | 4 | Operation code |
| lane_sel | input | 2 | Lane size select |
| opa | input | 64 | First operand (shift source) |
| opb | input | 64 | Second operand |
| shcnt | input | 64 | Shared shift count, unsigned |
| out_vld | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |

## Verification
The properties assume that the inputs are known, not X, whenever `in_vld` is high. They also assume that the inputs settle before the clock edge on which they are sampled. The stimulus meets both assumptions: every input is changed only on the falling clock edge, and every field is driven with a defined value from reset onward. Between requests the bench lowers `in_vld` and alters the operands. This exercises the hold properties without breaking the input assumptions.

// File: rtl/plsc_pkg.sv
package plsc_pkg;
    localparam int DW = 64;
    localparam int CW = 64;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_ANDN = 4'd3,
        OP_SLL  = 4'd4,
        OP_SRL  = 4'd5,
        OP_SRA  = 4'd6,
        OP_CEQ  = 4'd7,
        OP_CGT  = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        LN_B = 2'd0,
        LN_W = 2'd1,
        LN_D = 2'd2,
        LN_Q = 2'd3
    } lane_e;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
    } st_t;
endpackage

// File: rtl/plsc_bitwise.sv
module plsc_bitwise #(
    parameter int DW = 64
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res
);
    import plsc_pkg::*;

    always_comb begin
        unique case (op)
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            OP_ANDN: res = (~opa) & opb;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/plsc_shift.sv
module plsc_shift #(
    parameter int DW = 64,
    parameter int CW = 64
) (
    input  logic [3:0]    op,
    input  logic [1:0]    lane_sel,
    input  logic [DW-1:0] src,
    input  logic [CW-1:0] cnt,
    output logic [DW-1:0] res,
    output logic          ok
);
    import plsc_pkg::*;

    // variant index 0: 16-bit lanes, 1: 32-bit, 2: 64-bit
    localparam int NV = 3;

    logic [DW-1:0] sll_a [NV];
    logic [DW-1:0] srl_a [NV];
    logic [DW-1:0] sra_a [NV];

    for (genvar gi = 0; gi < NV; gi++) begin : g_size
        localparam int LW = 16 << gi;
        localparam int NL = DW / LW;
        localparam int SB = $clog2(LW);

        logic          big;
        logic [SB-1:0] amt;
        logic [DW-1:0] sll_w;
        logic [DW-1:0] srl_w;
        logic [DW-1:0] sra_w;

        assign big = |cnt[CW-1:SB];
        assign amt = cnt[SB-1:0];

        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] ln;
            assign ln = src[l*LW +: LW];
            assign sll_w[l*LW +: LW] = big ? '0 : (ln << amt);
            assign srl_w[l*LW +: LW] = big ? '0 : (ln >> amt);
            assign sra_w[l*LW +: LW] = big ? {LW{ln[LW-1]}}
                                           : LW'($signed(ln) >>> amt);
        end

        assign sll_a[gi] = sll_w;
        assign srl_a[gi] = srl_w;
        assign sra_a[gi] = sra_w;
    end

    logic [1:0] vidx;

    always_comb begin
        vidx = lane_sel - 2'd1;
        ok   = 1'b0;
        res  = '0;
        unique case (op)
            OP_SLL: begin
                ok = (lane_sel != LN_B);
                if (ok) res = sll_a[vidx];
            end
            OP_SRL: begin
                ok = (lane_sel != LN_B);
                if (ok) res = srl_a[vidx];
            end
            OP_SRA: begin
                ok = (lane_sel == LN_W) || (lane_sel == LN_D);
                if (ok) res = sra_a[vidx];
            end
            default: begin
                ok  = 1'b0;
                res = '0;
            end
        endcase
    end
endmodule

// File: rtl/plsc_compare.sv
module plsc_compare #(
    parameter int DW = 64
) (
    input  logic [3:0]    op,
    input  logic [1:0]    lane_sel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res,
    output logic          ok
);
    import plsc_pkg::*;

    // variant index 0: 8-bit lanes, 1: 16-bit, 2: 32-bit
    localparam int NV = 3;

    logic [DW-1:0] eq_a [NV];
    logic [DW-1:0] gt_a [NV];

    for (genvar gi = 0; gi < NV; gi++) begin : g_size
        localparam int LW = 8 << gi;
        localparam int NL = DW / LW;

        logic [DW-1:0] eq_w;
        logic [DW-1:0] gt_w;

        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] la;
            logic [LW-1:0] lb;
            assign la = opa[l*LW +: LW];
            assign lb = opb[l*LW +: LW];
            assign eq_w[l*LW +: LW] = {LW{la == lb}};
            assign gt_w[l*LW +: LW] = {LW{$signed(la) > $signed(lb)}};
        end

        assign eq_a[gi] = eq_w;
        assign gt_a[gi] = gt_w;
    end

    always_comb begin
        ok  = (lane_sel != LN_Q) && ((op == OP_CEQ) || (op == OP_CGT));
        res = '0;
        if (ok) begin
            res = (op == OP_CEQ) ? eq_a[lane_sel] : gt_a[lane_sel];
        end
    end
endmodule

// File: rtl/plsc_unit.sv
module plsc_unit #(
    parameter int DW = plsc_pkg::DW,
    parameter int CW = plsc_pkg::CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [3:0]    op,
    input  logic [1:0]    lane_sel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [CW-1:0] shcnt,
    output logic          out_vld,
    output logic [DW-1:0] result
);
    import plsc_pkg::*;

    logic [DW-1:0] bw_res;
    logic [DW-1:0] sh_res;
    logic [DW-1:0] cm_res;
    logic          sh_ok;
    logic          cm_ok;

    plsc_bitwise #(.DW(DW)) bw_i (
        .op  (op),
        .opa (opa),
        .opb (opb),
        .res (bw_res)
    );

    plsc_shift #(.DW(DW), .CW(CW)) sh_i (
        .op       (op),
        .lane_sel (lane_sel),
        .src      (opa),
        .cnt      (shcnt),
        .res      (sh_res),
        .ok       (sh_ok)
    );

    plsc_compare #(.DW(DW)) cm_i (
        .op       (op),
        .lane_sel (lane_sel),
        .opa      (opa),
        .opb      (opb),
        .res      (cm_res),
        .ok       (cm_ok)
    );

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
    } ust_t;

    ust_t st_d;
    ust_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            unique case (op)
                OP_AND, OP_OR, OP_XOR, OP_ANDN: st_d.res = bw_res;
                OP_SLL, OP_SRL, OP_SRA:         st_d.res = sh_ok ? sh_res : '0;
                OP_CEQ, OP_CGT:                 st_d.res = cm_ok ? cm_res : '0;
                default:                        st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign result  = st_q.res;
endmodule

// File: rtl/plsc_unit_chk.sv
module plsc_unit_chk #(
    parameter int DW = 64,
    parameter int CW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vld,
    input logic [3:0]    op,
    input logic [1:0]    lane_sel,
    input logic [DW-1:0] opa,
    input logic [DW-1:0] opb,
    input logic [CW-1:0] shcnt,
    input logic          out_vld,
    input logic [DW-1:0] result
);
    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (result == '0 && out_vld == 1'b0);
        end
    end

    p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(result));

    p_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 4'd0) |=> result == ($past(opa) & $past(opb)));

    p_andn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 4'd3) |=> result == (~$past(opa) & $past(opb)));

    p_lshift_big_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (op == 4'd4 || op == 4'd5) && shcnt >= CW'(DW))
        |=> result == '0);

    p_eq_self_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 4'd7 && lane_sel != 2'd3 && opa == opb)
        |=> result == '1);

    p_gt_self_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 4'd8 && opa == opb) |=> result == '0);

    p_bad_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op > 4'd8) |=> result == '0);
endmodule

bind plsc_unit plsc_unit_chk #(.DW(DW), .CW(CW)) chk_i (.*);

// File: tb/plsc_unit_tb.sv
module plsc_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  lane_sel = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [63:0] shcnt = '0;
    logic        out_vld;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plsc_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .op       (op),
        .lane_sel (lane_sel),
        .opa      (opa),
        .opb      (opb),
        .shcnt    (shcnt),
        .out_vld  (out_vld),
        .result   (result)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected value worked out from the requirement text
    function automatic logic [63:0] model(logic [3:0] o, logic [1:0] ls,
                                          logic [63:0] a, logic [63:0] b,
                                          logic [63:0] c);
        int lw;
        logic [63:0] m, out, la, lb, r;
        longint sa, sb;
        lw  = 8 << ls;
        m   = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        out = '0;
        case (o)
            4'd0: return a & b;
            4'd1: return a | b;
            4'd2: return a ^ b;
            4'd3: return ~a & b;
            4'd4, 4'd5: if (ls == 2'd0) return '0;
            4'd6: if (ls == 2'd0 || ls == 2'd3) return '0;
            4'd7, 4'd8: if (ls == 2'd3) return '0;
            default: return '0;
        endcase
        for (int i = 0; i < 64 / lw; i++) begin
            la = (a >> (i * lw)) & m;
            lb = (b >> (i * lw)) & m;
            sa = $signed(la << (64 - lw)) >>> (64 - lw);
            sb = $signed(lb << (64 - lw)) >>> (64 - lw);
            r  = '0;
            case (o)
                4'd4: r = (c >= 64'(lw)) ? '0 : (la << c[5:0]);
                4'd5: r = (c >= 64'(lw)) ? '0 : (la >> c[5:0]);
                4'd6: r = (c >= 64'(lw)) ? (sa < 0 ? '1 : '0)
                                         : 64'(sa >>> c[5:0]);
                4'd7: r = (la == lb) ? '1 : '0;
                4'd8: r = (sa > sb) ? '1 : '0;
                default: r = '0;
            endcase
            out = out | ((r & m) << (i * lw));
        end
        return out;
    endfunction

    task automatic run(string tag, logic [3:0] o, logic [1:0] ls,
                       logic [63:0] a, logic [63:0] b, logic [63:0] c);
        logic [63:0] exp;
        exp = model(o, ls, a, b, c);
        @(negedge clk);
        in_vld = 1'b1; op = o; lane_sel = ls; opa = a; opb = b; shcnt = c;
        @(negedge clk);
        in_vld = 1'b0;
        chk({tag, " result"}, result, exp);
        chk("R2 out_vld after request", {63'd0, out_vld}, 64'd1);
    endtask

    task automatic t_reset();
        chk("R1 result in reset", result, '0);
        chk("R1 out_vld in reset", {63'd0, out_vld}, 64'd0);
    endtask

    task automatic t_bitwise();
        logic [63:0] a = 64'hF0F0_A5A5_0000_FFFF;
        logic [63:0] b = 64'h0FF0_5A5A_FFFF_F00F;
        run("R4 and", 4'd0, 2'd2, a, b, '0);
        run("R4 or",  4'd1, 2'd0, a, b, '0);
        run("R4 xor", 4'd2, 2'd3, a, b, '0);
        run("R5 andn", 4'd3, 2'd1, a, b, '0);
    endtask

    task automatic t_shift_logical();
        logic [63:0] a = 64'h8123_4567_89AB_CDEF;
        run("R6 sll word",  4'd4, 2'd1, a, '0, 64'd4);
        run("R6 srl dword", 4'd5, 2'd2, a, '0, 64'd31);
        run("R6 sll quad",  4'd4, 2'd3, a, '0, 64'd63);
        run("R6 srl word zero count", 4'd5, 2'd1, a, '0, 64'd0);
    endtask

    task automatic t_shift_arith();
        run("R7 sra word",  4'd6, 2'd1, 64'h8000_7FFF_F00F_1234, '0, 64'd3);
        run("R7 sra dword", 4'd6, 2'd2, 64'h8765_4321_1234_5678, '0, 64'd17);
    endtask

    task automatic t_shift_big();
        logic [63:0] a = 64'hFFFF_8000_7FFF_0001;
        run("R8 sll word count 16",  4'd4, 2'd1, a, '0, 64'd16);
        run("R8 srl quad count 64",  4'd5, 2'd3, a, '0, 64'd64);
        run("R8 sll dword high bit", 4'd4, 2'd2, a, '0, 64'h8000_0000_0000_0001);
        run("R9 sra dword count 32", 4'd6, 2'd2, 64'h8000_0000_7FFF_FFFF, '0, 64'd32);
        run("R9 sra word huge",      4'd6, 2'd1, a, '0, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_cmp_eq();
        logic [63:0] a = 64'h1122_3344_5566_7788;
        logic [63:0] b = 64'h1122_3345_5566_0088;
        run("R10 eq byte",  4'd7, 2'd0, a, b, '0);
        run("R10 eq word",  4'd7, 2'd1, a, b, '0);
        run("R10 eq dword", 4'd7, 2'd2, a, b, '0);
    endtask

    task automatic t_cmp_gt();
        logic [63:0] a = 64'h7F80_0001_8000_0000;
        logic [63:0] b = 64'h807F_FFFF_7FFF_0000;
        run("R11 gt byte",  4'd8, 2'd0, a, b, '0);
        run("R11 gt word",  4'd8, 2'd1, a, b, '0);
        run("R11 gt dword", 4'd8, 2'd2, a, b, '0);
    endtask

    task automatic t_illegal();
        logic [63:0] a = 64'hDEAD_BEEF_CAFE_F00D;
        run("R12 setup", 4'd1, 2'd0, a, a, '0);
        run("R12 op 9",        4'd9,  2'd1, a, a, 64'd1);
        run("R4 or reload",    4'd1,  2'd0, a, a, '0);
        run("R12 sll byte",    4'd4,  2'd0, a, a, 64'd1);
        run("R4 or reload",    4'd1,  2'd0, a, a, '0);
        run("R12 sra quad",    4'd6,  2'd3, a, a, 64'd1);
        run("R4 or reload",    4'd1,  2'd0, a, a, '0);
        run("R12 ceq quad",    4'd7,  2'd3, a, a, '0);
        run("R4 or reload",    4'd1,  2'd0, a, a, '0);
        run("R12 op 15",       4'd15, 2'd2, a, a, '0);
    endtask

    task automatic t_hold();
        logic [63:0] keep;
        run("R4 xor before hold", 4'd2, 2'd0, 64'h1234_5678_9ABC_DEF0,
            64'hFFFF_0000_FFFF_0000, '0);
        keep = result;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            op = 4'd3; opa = 64'(k) * 64'h1111; opb = '1; shcnt = 64'(k);
        end
        chk("R3 result held while idle", result, keep);
        chk("R2 out_vld low while idle", {63'd0, out_vld}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 out_vld low before request", {63'd0, out_vld}, 64'd0);
        t_bitwise();
        t_shift_logical();
        t_shift_arith();
        t_shift_big();
        t_cmp_eq();
        t_cmp_gt();
        t_illegal();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule